// File: doc/BRIEF.md
# Dual 16-bit Tick-Driven Down-Counter Timers

This block holds two 16-bit down-counters that advance only on cycles where a prescaled tick enable is high. The tick nominally runs at one sixth of a 4.7 MHz clock; the divider sits outside the block. A host reaches both counters through 8-bit register halves, selected by a 4-bit index on a simple same-cycle read/write port. Read data is combinational from the index.

The first counter has a 16-bit reload latch. It runs down through zero into an all-ones underflow state, then reloads from the latch, so a full period is latch + 2 ticks. When the two-bit mode input selects continuous operation, each tick that brings this counter to zero sets a sticky interrupt flag and emits a one-cycle set pulse. The host can stage the latch without restarting the count, or load it and restart in one write. Flag-clear requests come from three places: a register read, a latch write, and a dedicated input.

The second counter has no reload. It is loaded from a written high byte joined with a staged low byte, and it wraps modulo 2^16 as it counts down.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, reads of indexes 4, 5, 6, 7, 8 and 9 all return 0xFF, and the counter-1 flag is low. This means counter 1 and its latch are 0xFFFF, the counter-2 staged low byte is 0x00 and counter 2 is 0xFFFF.
- R2: On each tick, counter 1 goes from N to N-1. From 0 it goes to 0xFFFF (the underflow state), and on the next tick it reloads the latch, giving latch+2 ticks per period. Without a tick it holds. A counter loaded with 0xFFFF by a write counts down to 0xFFFE; it is not treated as underflow.
- R3: When t1_mode_i equals 2'b01, a tick that makes counter 1 zero raises t1_flag_o and pulses t1_set_o high for exactly one cycle, on the same edge. With any other mode value, no flag is set and no pulse is emitted.
- R4: Writing index 4 or index 6 replaces only the low latch byte. The counter is not affected.
- R5: Writing index 5 places the data in the latch high byte, clears the flag and loads counter 1 with the full new latch.
- R6: Writing index 7 places the data in the latch high byte and clears the flag. Counter 1 is left as it was.
- R7: A read (rd_i high) of index 4 clears the flag, and so does flag_clr_i. If a set and any clear occur in the same cycle, the set wins.
- R8: Read map by index: 4 returns counter 1 bits 7:0, 5 returns counter 1 bits 15:8, 6 returns latch low, 7 returns latch high, 8 returns counter 2 bits 7:0, 9 returns counter 2 bits 15:8. Every other index reads 0x00.
- R9: Writing index 8 stores only the counter-2 low byte and leaves the count alone. Writing index 9 loads counter 2 with {data, stored low byte}. Each tick decrements counter 2, wrapping from 0 to 0xFFFF. Counter 2 never raises a flag.
- R10: A load write (index 5 or 9) in a tick cycle takes precedence: the counter takes the loaded value and the tick is dropped for that counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle count enable from the prescaler |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (read side effects only) |
| addr_i | input | 4 | Register index |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| t1_mode_i | input | 2 | Counter-1 interrupt mode; 2'b01 is continuous |
| flag_clr_i | input | 1 | Request to clear the counter-1 flag |
| t1_flag_o | output | 1 | Sticky counter-1 interrupt flag |
| t1_set_o | output | 1 | One-cycle pulse when the flag is set |

## Verification
Counter 1 is run in two ways: with the latch staged but not started, and then started in each mode. Running it in the non-continuous mode shows that counting goes on while interrupts are suppressed. In continuous mode, set pulses are spaced latch+2 cycles apart, and this spacing is what separates a correct underflow state from an off-by-one reload. A zero crossing is forced in the same cycle as a clear request, which shows whether the design gets the set-over-clear precedence right. Counter 2 is loaded with zero and then ticked, which exposes the modulo wrap. Load writes are issued together with ticks to confirm that the write takes precedence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] IDX_T1_LO  = 4'd4;
  localparam logic [3:0] IDX_T1_HI  = 4'd5;
  localparam logic [3:0] IDX_L1_LO  = 4'd6;
  localparam logic [3:0] IDX_L1_HI  = 4'd7;
  localparam logic [3:0] IDX_T2_LO  = 4'd8;
  localparam logic [3:0] IDX_T2_HI  = 4'd9;
  localparam logic [1:0] MODE_CONT  = 2'b01;
endpackage

// File: rtl/tmr_reload_unit.sv
module tmr_reload_unit #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         cont_i,
  input  logic         ld_lo_i,
  input  logic         ld_hi_i,
  input  logic         start_i,
  input  logic [7:0]   wdata_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] latch_o,
  output logic         flag_o,
  output logic         set_o
);
  localparam int HW = W - 8;
  localparam logic [W-1:0] ALL1 = '1;

  logic [W-1:0] cnt_q, cnt_d, latch_q, latch_d;
  logic         wrap_q, wrap_d, hit_zero, flag_q, set_q;

  always_comb begin
    latch_d = latch_q;
    if (ld_lo_i) latch_d[7:0] = wdata_i;
    if (ld_hi_i || start_i) latch_d[W-1:8] = wdata_i[HW-1:0];
    cnt_d    = cnt_q;
    wrap_d   = wrap_q;
    hit_zero = 1'b0;
    if (start_i) begin
      cnt_d  = latch_d;
      wrap_d = 1'b0;
    end else if (tick_i) begin
      if (wrap_q) begin
        cnt_d  = latch_q;       // reload after the underflow tick
        wrap_d = 1'b0;
      end else if (cnt_q == '0) begin
        cnt_d  = ALL1;
        wrap_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      hit_zero = (cnt_d == '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= ALL1;
      latch_q <= ALL1;
      wrap_q  <= 1'b0;
      flag_q  <= 1'b0;
      set_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      latch_q <= latch_d;
      wrap_q  <= wrap_d;
      set_q   <= hit_zero && cont_i;
      if (hit_zero && cont_i) flag_q <= 1'b1;   // set beats clear
      else if (clr_i)         flag_q <= 1'b0;
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
  assign flag_o  = flag_q;
  assign set_o   = set_q;
endmodule

// File: rtl/tmr_oneshot_unit.sv
module tmr_oneshot_unit #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_lo_i,
  input  logic         start_i,
  input  logic [7:0]   wdata_i,
  output logic [W-1:0] cnt_o,
  output logic [7:0]   lo_o
);
  localparam int HW = W - 8;

  logic [W-1:0] cnt_q;
  logic [7:0]   lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      lo_q  <= '0;
    end else begin
      if (ld_lo_i) lo_q <= wdata_i;
      if (start_i)     cnt_q <= {wdata_i[HW-1:0], lo_q};
      else if (tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lo_o  = lo_q;
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [3:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic [1:0] t1_mode_i,
  input  logic       flag_clr_i,
  output logic       t1_flag_o,
  output logic       t1_set_o
);
  logic [W-1:0] t1_cnt, t1_latch, t2_cnt;
  logic [7:0]   t2_lo;
  logic         wr4, wr5, wr6, wr7, wr8, wr9, t1_clr;

  assign wr4 = wr_i && (addr_i == IDX_T1_LO);
  assign wr5 = wr_i && (addr_i == IDX_T1_HI);
  assign wr6 = wr_i && (addr_i == IDX_L1_LO);
  assign wr7 = wr_i && (addr_i == IDX_L1_HI);
  assign wr8 = wr_i && (addr_i == IDX_T2_LO);
  assign wr9 = wr_i && (addr_i == IDX_T2_HI);
  assign t1_clr = wr5 || wr7 || flag_clr_i || (rd_i && addr_i == IDX_T1_LO);

  tmr_reload_unit #(.W(W)) u_t1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .cont_i  (t1_mode_i == MODE_CONT),
    .ld_lo_i (wr4 || wr6),
    .ld_hi_i (wr7),
    .start_i (wr5),
    .wdata_i (wdata_i),
    .clr_i   (t1_clr),
    .cnt_o   (t1_cnt),
    .latch_o (t1_latch),
    .flag_o  (t1_flag_o),
    .set_o   (t1_set_o)
  );

  tmr_oneshot_unit #(.W(W)) u_t2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .ld_lo_i (wr8),
    .start_i (wr9),
    .wdata_i (wdata_i),
    .cnt_o   (t2_cnt),
    .lo_o    (t2_lo)
  );

  always_comb begin
    unique case (addr_i)
      IDX_T1_LO: rdata_o = t1_cnt[7:0];
      IDX_T1_HI: rdata_o = 8'(t1_cnt[W-1:8]);
      IDX_L1_LO: rdata_o = t1_latch[7:0];
      IDX_L1_HI: rdata_o = 8'(t1_latch[W-1:8]);
      IDX_T2_LO: rdata_o = t2_cnt[7:0];
      IDX_T2_HI: rdata_o = 8'(t2_cnt[W-1:8]);
      default:   rdata_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         wr_i,
  input logic [3:0]   addr_i,
  input logic [7:0]   wdata_i,
  input logic [1:0]   t1_mode_i,
  input logic         t1_flag_o,
  input logic         t1_set_o,
  input logic [W-1:0] t1_cnt,
  input logic [W-1:0] t1_latch,
  input logic [W-1:0] t2_cnt,
  input logic [7:0]   t2_lo
);
  logic w5, w7, w9;
  assign w5 = wr_i && addr_i == 4'd5;
  assign w7 = wr_i && addr_i == 4'd7;
  assign w9 = wr_i && addr_i == 4'd9;

  a_r2_zero_to_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !w5 && t1_cnt == '0 |=> t1_cnt == '1);
  a_r2_hold_no_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !w5 |=> $stable(t1_cnt));
  a_r3_set_in_cont: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t1_set_o |-> t1_flag_o && $past(t1_mode_i) == 2'b01);
  a_r5_load_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w5 |=> t1_cnt == {$past(wdata_i), $past(t1_latch[7:0])} && !t1_flag_o);
  a_r6_clear_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w7 && !tick_i |=> $stable(t1_cnt) && !t1_flag_o);
  a_r9_t2_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w9 |=> t2_cnt == {$past(wdata_i), $past(t2_lo)});
  a_r9_t2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !w9 |=> t2_cnt == W'($past(t2_cnt) - 1'b1));
endmodule

bind dual_tick_timer tmr_pair_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .t1_mode_i (t1_mode_i),
  .t1_flag_o (t1_flag_o),
  .t1_set_o  (t1_set_o),
  .t1_cnt    (t1_cnt),
  .t1_latch  (t1_latch),
  .t2_cnt    (t2_cnt),
  .t2_lo     (t2_lo)
);

// File: tb/tb_dual_tick_timer.sv
module tb_dual_tick_timer;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, flag_clr_i = 1'b0;
  logic [3:0] addr_i = 4'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [1:0] t1_mode_i = 2'b00;
  logic [7:0] rdata_o;
  logic       t1_flag_o, t1_set_o;

  int errors = 0, checks = 0, cyc = 0;
  int m_l1, m_c1, m_wrap, m_flag, m_set, m_l2, m_c2;
  int last_set = -1, last_period = 0;

  always #4 clk = ~clk;

  dual_tick_timer dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .t1_mode_i(t1_mode_i), .flag_clr_i(flag_clr_i),
    .t1_flag_o(t1_flag_o), .t1_set_o(t1_set_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_rd(input int a);
    case (a)
      4: return m_c1 & 255;
      5: return m_c1 >> 8;
      6: return m_l1 & 255;
      7: return m_l1 >> 8;
      8: return m_c2 & 255;
      9: return m_c2 >> 8;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, updated on each edge
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_l1 = 16'hFFFF; m_c1 = 16'hFFFF; m_wrap = 0; m_flag = 0; m_set = 0;
      m_l2 = 0; m_c2 = 16'hFFFF;
    end else begin
      int old_l1, hit, clr;
      old_l1 = m_l1; hit = 0;
      clr = (wr_i && (addr_i == 5 || addr_i == 7)) || flag_clr_i || (rd_i && addr_i == 4);
      if (wr_i && (addr_i == 4 || addr_i == 6)) m_l1 = (m_l1 & 16'hFF00) | wdata_i;
      if (wr_i && (addr_i == 5 || addr_i == 7)) m_l1 = (m_l1 & 255) | (int'(wdata_i) << 8);
      if (wr_i && addr_i == 5) begin
        m_c1 = m_l1; m_wrap = 0;
      end else if (tick_i) begin
        if (m_wrap == 1) begin m_c1 = old_l1; m_wrap = 0; end
        else if (m_c1 == 0) begin m_c1 = 16'hFFFF; m_wrap = 1; end
        else m_c1 = m_c1 - 1;
        hit = (m_c1 == 0);
      end
      m_set = (hit == 1 && t1_mode_i == 2'b01) ? 1 : 0;
      if (m_set == 1) m_flag = 1;
      else if (clr != 0) m_flag = 0;
      if (wr_i && addr_i == 9) m_c2 = (int'(wdata_i) << 8) | m_l2;
      else if (tick_i) m_c2 = (m_c2 + 16'hFFFF) & 16'hFFFF;
      if (wr_i && addr_i == 8) m_l2 = wdata_i;
    end
  end

  // every-clock comparison after outputs settle
  always @(posedge clk) begin
    #2;
    cyc++;
    if (rst_ni) begin
      chk("R3 flag", int'(t1_flag_o), m_flag);
      chk("R3 set pulse", int'(t1_set_o), m_set);
      chk("R8 rdata", int'(rdata_o), exp_rd(int'(addr_i)));
      if (t1_set_o) begin
        if (last_set >= 0) last_period = cyc - last_set;
        last_set = cyc;
      end
    end
  end

  task automatic step(input bit w, input bit r, input int a, input int d,
                      input bit t, input bit c);
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = 4'(a); wdata_i = 8'(d); tick_i = t; flag_clr_i = c;
  endtask

  task automatic peek(input int a, input int exp, input string tag);
    step(0, 0, a, 0, 0, 0);
    #1 chk(tag, int'(rdata_o), exp);
  endtask

  initial begin : watchdog
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    #13 rst_ni = 1'b1;
    // R1 reset image
    peek(4, 8'hFF, "R1 t1 lo"); peek(5, 8'hFF, "R1 t1 hi");
    peek(6, 8'hFF, "R1 latch lo"); peek(7, 8'hFF, "R1 latch hi");
    peek(8, 8'hFF, "R1 t2 lo"); peek(9, 8'hFF, "R1 t2 hi");
    chk("R1 flag", int'(t1_flag_o), 0);
    peek(0, 0, "R8 unused index"); peek(15, 0, "R8 unused index");
    // R4 latch low only
    step(1, 0, 6, 8'h05, 0, 0);
    peek(6, 8'h05, "R4 latch lo"); peek(7, 8'hFF, "R4 latch hi kept");
    peek(4, 8'hFF, "R4 counter kept");
    // R5 load
    step(1, 0, 5, 8'h00, 0, 0);
    peek(4, 8'h05, "R5 counter lo"); peek(5, 8'h00, "R5 counter hi");
    // R2 counting, mode 00 -> R3 no flag
    for (int i = 0; i < 5; i++) step(0, 0, 4, 0, 1, 0);
    peek(4, 8'h00, "R2 at zero");
    chk("R3 no flag outside continuous", int'(t1_flag_o), 0);
    step(0, 0, 4, 0, 1, 0);
    peek(5, 8'hFF, "R2 underflow state");
    step(0, 0, 4, 0, 1, 0);
    peek(4, 8'h05, "R2 reload from latch");
    // continuous mode period
    t1_mode_i = 2'b01;
    step(1, 0, 5, 8'h00, 0, 0);
    for (int i = 0; i < 24; i++) step(0, 0, 4, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R2 period latch+2", last_period, 7);
    chk("R3 flag raised", int'(t1_flag_o), 1);
    // R7 read clears
    step(0, 1, 4, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R7 read clears flag", int'(t1_flag_o), 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R7 clear input", int'(t1_flag_o), 0);
    // R6 high write without reload
    step(0, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0);
    v = m_c1;
    step(1, 0, 7, 8'h01, 0, 0);
    peek(7, 8'h01, "R6 latch hi");
    peek(4, v & 255, "R6 counter lo kept"); peek(5, v >> 8, "R6 counter hi kept");
    chk("R6 flag cleared", int'(t1_flag_o), 0);
    // R7 set wins over clear
    step(1, 0, 4, 8'h01, 0, 0);
    step(1, 0, 5, 8'h00, 0, 0);
    step(0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R7 set wins", int'(t1_flag_o), 1);
    // R9 counter 2
    step(0, 0, 8, 0, 0, 0); #1 v = int'(rdata_o);
    step(1, 0, 8, 8'h00, 0, 0);
    peek(8, v, "R9 low write keeps count");
    step(1, 0, 9, 8'h00, 0, 0);
    peek(8, 0, "R9 loaded zero");
    step(0, 0, 8, 0, 1, 0);
    peek(8, 8'hFF, "R9 wrap lo"); peek(9, 8'hFF, "R9 wrap hi");
    // R10 load beats tick
    step(1, 0, 9, 8'h12, 1, 0);
    peek(9, 8'h12, "R10 t2 hi"); peek(8, 8'h00, "R10 t2 lo");
    step(1, 0, 5, 8'h02, 1, 0);
    peek(5, 8'h02, "R10 t1 hi"); peek(4, 8'h01, "R10 t1 lo");
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule